// File: doc/BRIEF.md
# DMA Bus-Mode Transfer Sequencer

This block is a single-channel DMA engine that moves data in dual-address fashion. Each transfer unit is a read from the source address and then a write of the same data to the destination address. The engine must win the system bus through a request/grant handshake before it issues any memory cycle. A configuration bit picks how long it keeps the bus. In cycle-steal operation it hands the bus back after every unit. In burst operation it keeps the bus from the first grant until the transfer ends.

Software loads the source address, destination address, unit count, unit size, bus mode and request source, then pulses a start strobe. Transfer requests come from one of two places. The first is an active-low level pin from an external device. The second is a one-cycle strobe from an internal requester: an auto requester, a serial port or an A/D converter. Burst operation is not allowed with the serial or A/D requesters. If it is configured with one of them, the engine falls back to cycle-steal and reports a configuration error. In burst operation with the external level request, the engine gives up the bus early when the pin is released. The unit already under way is finished first.

Top module: `dma_bus_sequencer`

## Requirements
- R1: After reset, bus_req, mem_rd, mem_wr, busy, done and cfg_err are all 0. A cfg_start pulse while busy is 0 loads the configuration. In the next cycle busy is 1 and done is 0 when cfg_count is nonzero.
- R2: bus_req rises only after a transfer request. That is ext_req_n low for request source 0, or a pending int_req strobe for request sources 1, 2 and 3. mem_rd and mem_wr are asserted only while both bus_req and bus_grant are high.
- R3: Every unit is one or more read cycles followed by the same number of write cycles. Each write carries the data returned by the matching read. Unit code 3 (16-byte block) is four longword reads at source offsets +0, +4, +8, +12, then four longword writes at the same destination offsets.
- R4: Unit codes 0, 1, 2 and 3 select 1, 2, 4 and 16 bytes. After every unit, both the source and destination addresses advance by that many bytes. mem_size shows 0 for byte, 1 for word and 2 for longword, and block beats use 2.
- R5: In cycle-steal mode (cfg_burst=0), bus_req drops in the cycle after the last write of every unit. The next unit waits for a new transfer request, so the bus is acquired once per unit.
- R6: In burst mode with request source 0 held low or request source 1, the bus is acquired once. Units follow each other with no gap until the count runs out.
- R7: In burst mode with request source 0, if ext_req_n is high in the last write cycle of a unit, bus_req drops in the next cycle. The engine stays busy, and it re-requests the bus once ext_req_n goes low again.
- R8: If cfg_burst=1 is started with request source 2 (serial) or 3 (A/D), cfg_err is set and the transfer runs in cycle-steal mode. Any other start clears cfg_err.
- R9: The unit count decrements once per unit. In the cycle after the last write of the final unit, done becomes 1 and busy and bus_req become 0. A start with cfg_count=0 sets done at once with no bus activity.
- R10: mem_rd and mem_wr are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_start | input | 1 | Start strobe; loads the configuration when idle |
| cfg_src_addr | input | AW | First source byte address |
| cfg_dst_addr | input | AW | First destination byte address |
| cfg_count | input | CW | Number of units to move |
| cfg_unit | input | 2 | Unit size code: 0 byte, 1 word, 2 longword, 3 16-byte block |
| cfg_burst | input | 1 | 1 selects burst, 0 selects cycle-steal |
| cfg_req_sel | input | 2 | Request source: 0 external level, 1 auto, 2 serial, 3 A/D |
| ext_req_n | input | 1 | Active-low level transfer request |
| int_req | input | 1 | One-cycle request strobe from the selected internal source |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_grant | input | 1 | Bus grant from the arbiter |
| mem_rd | output | 1 | Read cycle strobe |
| mem_wr | output | 1 | Write cycle strobe |
| mem_addr | output | AW | Byte address of the current cycle |
| mem_size | output | 2 | Access size: 0 byte, 1 word, 2 longword |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid in the read cycle |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer completed; held until the next start |
| cfg_err | output | 1 | Burst was asked for with a source that forbids it |

## Verification
Random transfers mix all four unit sizes, both bus modes and all four request sources. The bus arbiter in the bench grants after a random delay. Counting bus acquisitions per transfer separates cycle-steal from burst. It also shows the serial and A/D fallback, which must count one acquisition per unit even though burst was asked for. Every read and write is compared against addresses and data predicted in the bench, and this exposes wrong strides, wrong beat order and wrong size codes. Directed cases cover the rest:
- a zero count;
- an internal source left without a second strobe, which must stall between units;
- an external level released in the middle of a burst, which must stop the bus after the current unit and resume when the level returns.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [1:0] {
    UNIT_BYTE  = 2'd0,
    UNIT_WORD  = 2'd1,
    UNIT_LONG  = 2'd2,
    UNIT_BLK16 = 2'd3
  } unit_e;

  typedef enum logic [1:0] {
    RQ_EXT    = 2'd0,
    RQ_AUTO   = 2'd1,
    RQ_SERIAL = 2'd2,
    RQ_ADC    = 2'd3
  } rqsrc_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WAIT  = 3'd1,
    ST_ARB   = 3'd2,
    ST_READ  = 3'd3,
    ST_WRITE = 3'd4
  } seq_st_e;

  localparam int BLK_BEATS  = 4;
  localparam int BEAT_BYTES = 4;

  // bytes moved by one unit
  function automatic logic [4:0] unit_bytes(input unit_e u);
    case (u)
      UNIT_BYTE: return 5'd1;
      UNIT_WORD: return 5'd2;
      UNIT_LONG: return 5'd4;
      default:   return 5'd16;
    endcase
  endfunction

  // bus cycles per direction for one unit
  function automatic logic [2:0] unit_beats(input unit_e u);
    return (u == UNIT_BLK16) ? 3'(BLK_BEATS) : 3'd1;
  endfunction

  // access size code shown on the memory side
  function automatic logic [1:0] bus_size(input unit_e u);
    return (u == UNIT_BLK16) ? 2'd2 : 2'(u);
  endfunction

  function automatic logic burst_permitted(input rqsrc_e s);
    return !(s == RQ_SERIAL || s == RQ_ADC);
  endfunction

endpackage

// File: rtl/dma_req_unit.sv
module dma_req_unit
  import dma_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clr,
  input  logic   take,
  input  rqsrc_e sel,
  input  logic   ext_req_n,
  input  logic   int_req,
  output logic   req_now
);

  logic pending_q;

  // a fresh strobe wins over consumption in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pending_q <= 1'b0;
    else if (int_req)        pending_q <= 1'b1;
    else if (take || clr)    pending_q <= 1'b0;
  end

  assign req_now = (sel == RQ_EXT) ? !ext_req_n : pending_q;

endmodule

// File: rtl/dma_xfer_regs.sv
module dma_xfer_regs
  import dma_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 8
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] ld_src,
  input  logic [AW-1:0] ld_dst,
  input  logic [CW-1:0] ld_cnt,
  input  unit_e         ld_unit,
  input  logic          step,
  output logic [AW-1:0] src_q,
  output logic [AW-1:0] dst_q,
  output logic [CW-1:0] cnt_q,
  output unit_e         unit_q,
  output logic          last_unit
);

  logic [AW-1:0] stride;

  assign stride    = AW'(unit_bytes(unit_q));
  assign last_unit = (cnt_q == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      unit_q <= UNIT_BYTE;
    end else if (load) begin
      src_q  <= ld_src;
      dst_q  <= ld_dst;
      cnt_q  <= ld_cnt;
      unit_q <= ld_unit;
    end else if (step) begin
      src_q  <= src_q + stride;
      dst_q  <= dst_q + stride;
      cnt_q  <= cnt_q - CW'(1);
    end
  end

endmodule

// File: rtl/dma_beat_buf.sv
module dma_beat_buf #(
  parameter int DW    = 32,
  parameter int DEPTH = 4
)(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_idx,
  input  logic [DW-1:0]            wr_data,
  input  logic [$clog2(DEPTH)-1:0] rd_idx,
  output logic [DW-1:0]            rd_data
);

  localparam int IW = $clog2(DEPTH);

  logic [DW-1:0] ent_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++)
        if (wr_en && wr_idx == IW'(i)) ent_q[i] <= wr_data;
    end
  end

  assign rd_data = ent_q[rd_idx];

endmodule

// File: rtl/dma_bus_sequencer.sv
module dma_bus_sequencer
  import dma_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 8
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_start,
  input  logic [AW-1:0] cfg_src_addr,
  input  logic [AW-1:0] cfg_dst_addr,
  input  logic [CW-1:0] cfg_count,
  input  logic [1:0]    cfg_unit,
  input  logic          cfg_burst,
  input  logic [1:0]    cfg_req_sel,
  input  logic          ext_req_n,
  input  logic          int_req,
  output logic          bus_req,
  input  logic          bus_grant,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    mem_size,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          done,
  output logic          cfg_err
);

  localparam int BW = $clog2(BLK_BEATS);

  seq_st_e       st_q, st_d;
  logic [BW-1:0] beat_q, beat_d, last_beat;
  logic          en_q, done_q, err_q, burst_q;
  rqsrc_e        sel_q;

  // named internal events, also used by the bound checker
  logic          start_ok, cfg_bad, unit_end, last_unit;
  logic          burst_eff, src_is_ext, hold_bus, take, req_now;
  logic [AW-1:0] src_q, dst_q;
  logic [CW-1:0] cnt_q;
  unit_e         unit_q;
  logic [AW-1:0] beat_off;

  assign start_ok   = cfg_start && !en_q;
  assign cfg_bad    = cfg_burst && !burst_permitted(rqsrc_e'(cfg_req_sel));
  assign burst_eff  = burst_q;
  assign src_is_ext = (sel_q == RQ_EXT);
  assign last_beat  = BW'(unit_beats(unit_q) - 3'd1);
  assign unit_end   = (st_q == ST_WRITE) && (beat_q == last_beat);
  assign hold_bus   = burst_q && (!src_is_ext || !ext_req_n);
  assign take       = ((st_q == ST_WAIT) && req_now) ||
                      (unit_end && !last_unit && hold_bus);

  dma_req_unit u_req (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (start_ok),
    .take      (take),
    .sel       (sel_q),
    .ext_req_n (ext_req_n),
    .int_req   (int_req),
    .req_now   (req_now)
  );

  dma_xfer_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start_ok),
    .ld_src    (cfg_src_addr),
    .ld_dst    (cfg_dst_addr),
    .ld_cnt    (cfg_count),
    .ld_unit   (unit_e'(cfg_unit)),
    .step      (unit_end),
    .src_q     (src_q),
    .dst_q     (dst_q),
    .cnt_q     (cnt_q),
    .unit_q    (unit_q),
    .last_unit (last_unit)
  );

  dma_beat_buf #(.DW(DW), .DEPTH(BLK_BEATS)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (st_q == ST_READ),
    .wr_idx  (beat_q),
    .wr_data (mem_rdata),
    .rd_idx  (beat_q),
    .rd_data (mem_wdata)
  );

  // sequencing
  always_comb begin
    st_d   = st_q;
    beat_d = beat_q;
    case (st_q)
      ST_IDLE:  if (start_ok && cfg_count != '0) st_d = ST_WAIT;
      ST_WAIT:  if (req_now) st_d = ST_ARB;
      ST_ARB:   if (bus_grant) begin
                  st_d   = ST_READ;
                  beat_d = '0;
                end
      ST_READ:  if (beat_q == last_beat) begin
                  st_d   = ST_WRITE;
                  beat_d = '0;
                end else begin
                  beat_d = beat_q + BW'(1);
                end
      ST_WRITE: if (!unit_end) begin
                  beat_d = beat_q + BW'(1);
                end else begin
                  beat_d = '0;
                  if (last_unit)     st_d = ST_IDLE;
                  else if (hold_bus) st_d = ST_READ;
                  else               st_d = ST_WAIT;
                end
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      beat_q <= '0;
    end else begin
      st_q   <= st_d;
      beat_q <= beat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      burst_q <= 1'b0;
      sel_q   <= RQ_EXT;
    end else if (start_ok) begin
      en_q    <= (cfg_count != '0);
      done_q  <= (cfg_count == '0);
      err_q   <= cfg_bad;
      burst_q <= cfg_burst && !cfg_bad;
      sel_q   <= rqsrc_e'(cfg_req_sel);
    end else if (unit_end && last_unit) begin
      en_q    <= 1'b0;
      done_q  <= 1'b1;
    end
  end

  assign beat_off = AW'(beat_q) * AW'(BEAT_BYTES);
  assign bus_req  = (st_q == ST_ARB) || (st_q == ST_READ) || (st_q == ST_WRITE);
  assign mem_rd   = (st_q == ST_READ);
  assign mem_wr   = (st_q == ST_WRITE);
  assign mem_addr = (mem_rd ? src_q : dst_q) + beat_off;
  assign mem_size = bus_size(unit_q);
  assign busy     = en_q;
  assign done     = done_q;
  assign cfg_err  = err_q;

endmodule

// File: rtl/dma_seq_checker.sv
module dma_seq_checker #(
  parameter int CW = 8
)(
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_burst,
  input logic [1:0]    cfg_req_sel,
  input logic          ext_req_n,
  input logic          bus_req,
  input logic          bus_grant,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic          busy,
  input logic          done,
  input logic          cfg_err,
  input logic          start_ok,
  input logic          unit_end,
  input logic          last_unit,
  input logic          burst_eff,
  input logic          src_is_ext,
  input logic [CW-1:0] cnt_q
);

  assert_rd_wr_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  assert_strobe_granted_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> (bus_req && bus_grant));

  assert_write_follows_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_wr) |-> $past(mem_rd));

  assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    unit_end |=> cnt_q == $past(cnt_q) - CW'(1));

  assert_final_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_end && last_unit) |=> (done && !busy && !bus_req));

  assert_steal_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_end && !burst_eff) |=> !bus_req);

  assert_burst_back_to_back_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_end && burst_eff && !last_unit && !src_is_ext) |=> mem_rd);

  assert_level_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_end && burst_eff && src_is_ext && ext_req_n) |=> (!bus_req && busy));

  assert_cfg_fallback_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ok && cfg_burst && cfg_req_sel[1]) |=> (cfg_err && !burst_eff));

endmodule

bind dma_bus_sequencer dma_seq_checker #(.CW(CW)) u_seq_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_burst  (cfg_burst),
  .cfg_req_sel(cfg_req_sel),
  .ext_req_n  (ext_req_n),
  .bus_req    (bus_req),
  .bus_grant  (bus_grant),
  .mem_rd     (mem_rd),
  .mem_wr     (mem_wr),
  .busy       (busy),
  .done       (done),
  .cfg_err    (cfg_err),
  .start_ok   (start_ok),
  .unit_end   (unit_end),
  .last_unit  (last_unit),
  .burst_eff  (burst_eff),
  .src_is_ext (src_is_ext),
  .cnt_q      (cnt_q)
);

// File: tb/tb_dma_bus_sequencer.sv
module tb_dma_bus_sequencer;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_start = 1'b0;
  logic [AW-1:0] cfg_src_addr = '0;
  logic [AW-1:0] cfg_dst_addr = '0;
  logic [CW-1:0] cfg_count = '0;
  logic [1:0]    cfg_unit = '0;
  logic          cfg_burst = 1'b0;
  logic [1:0]    cfg_req_sel = '0;
  logic          ext_req_n = 1'b1;
  logic          int_req = 1'b0;
  logic          bus_req;
  logic          bus_grant = 1'b0;
  logic          mem_rd, mem_wr;
  logic [AW-1:0] mem_addr;
  logic [1:0]    mem_size;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata;
  logic          busy, done, cfg_err;

  always #2 clk = ~clk;

  dma_bus_sequencer #(.AW(AW), .DW(DW), .CW(CW)) dut (.*);

  function automatic logic [31:0] model(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A3C, a[31:16] + 16'h1357};
  endfunction
  assign mem_rdata = model(mem_addr);

  function automatic int ubytes(input logic [1:0] u);
    return (u == 2'd3) ? 16 : (1 << u);
  endfunction
  function automatic int ubeats(input logic [1:0] u);
    return (u == 2'd3) ? 4 : 1;
  endfunction

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // monitor state
  bit          m_on = 0;
  bit          m_fin = 0;
  bit          prev_req = 0;
  logic [31:0] m_src, m_dst;
  logic [1:0]  m_unit;
  int          m_cnt, m_op, m_acq;

  // bus arbiter model: random grant latency
  initial begin
    int gd;
    gd = 0;
    forever begin
      @(negedge clk);
      if (!bus_req) begin
        bus_grant = 1'b0;
        gd = $urandom % 3;
      end else if (gd == 0) bus_grant = 1'b1;
      else gd--;
    end
  end

  // memory-side observer
  initial begin
    forever begin
      @(negedge clk);
      if (m_on) begin
        if (m_fin) begin
          chk(done && !busy && !bus_req, "R9 release after final write", {done, busy, bus_req}, 3'b100);
          m_fin = 0;
        end
        if (bus_req && !prev_req) m_acq++;
        prev_req = bus_req;
        if (mem_rd || mem_wr) begin
          int bt, u, r, b;
          bit is_rd;
          logic [31:0] ea, sa;
          bt = ubeats(m_unit);
          u = m_op / (2 * bt);
          r = m_op % (2 * bt);
          is_rd = (r < bt);
          b = is_rd ? r : r - bt;
          sa = m_src + 32'(u * ubytes(m_unit) + 4 * b);
          ea = is_rd ? sa : m_dst + 32'(u * ubytes(m_unit) + 4 * b);
          chk(mem_rd == is_rd && !(mem_rd && mem_wr), "R3 R10 cycle kind", {mem_rd, mem_wr}, {is_rd, !is_rd});
          chk(mem_addr == ea, "R4 cycle address", mem_addr, ea);
          chk(mem_size == ((m_unit == 2'd3) ? 2'd2 : m_unit), "R4 size code", mem_size, m_unit);
          chk(bus_grant && bus_req, "R2 strobe under grant", {bus_req, bus_grant}, 2'b11);
          if (!is_rd) chk(mem_wdata == model(sa), "R3 write data", mem_wdata, model(sa));
          if (u == m_cnt - 1 && !is_rd && b == bt - 1) m_fin = 1;
          m_op++;
        end
      end
    end
  end

  task automatic launch(input logic [31:0] s, input logic [31:0] d, input int n,
                        input logic [1:0] u, input bit bst, input logic [1:0] rs);
    cfg_src_addr = s; cfg_dst_addr = d; cfg_count = CW'(n);
    cfg_unit = u; cfg_burst = bst; cfg_req_sel = rs;
    m_src = s; m_dst = d; m_unit = u; m_cnt = n;
    m_op = 0; m_acq = 0; m_fin = 0; prev_req = 0; m_on = 1;
    @(negedge clk); cfg_start = 1'b1;
    @(negedge clk); cfg_start = 1'b0;
    chk(busy == (n != 0) && done == (n == 0), "R1 state after start", {busy, done}, {n != 0, n == 0});
    chk(cfg_err == (bst && rs[1]), "R8 config error flag", cfg_err, bst && rs[1]);
  endtask

  task automatic pulse_int();
    int_req = 1'b1;
    @(negedge clk); int_req = 1'b0;
    while (!bus_req && busy) @(negedge clk);
    while (bus_req) @(negedge clk);
  endtask

  task automatic finish(input int n, input int exp_acq, input string tag);
    while (busy) @(negedge clk);
    ext_req_n = 1'b1;
    repeat (2) @(negedge clk);
    m_on = 0;
    chk(done && !busy && !bus_req, "R9 completed", {done, busy, bus_req}, 3'b100);
    chk(m_op == 2 * ubeats(m_unit) * n, "R3 cycle total", m_op, 2 * ubeats(m_unit) * n);
    chk(m_acq == exp_acq, tag, m_acq, exp_acq);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk({bus_req, mem_rd, mem_wr, busy, done, cfg_err} == 6'b0, "R1 held in reset", {bus_req, mem_rd, mem_wr, busy, done, cfg_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({bus_req, mem_rd, mem_wr, busy, done, cfg_err} == 6'b0, "R1 reset state", {bus_req, mem_rd, mem_wr, busy, done, cfg_err}, 0);

    // zero count: immediate completion, no bus activity
    launch(32'h100, 32'h200, 0, 2'd2, 1'b0, 2'd0);
    repeat (4) @(negedge clk);
    m_on = 0;
    chk(m_op == 0 && m_acq == 0 && done, "R9 zero count", m_op, 0);

    // 16-byte block, burst, auto source
    launch(32'h1000, 32'h8000, 3, 2'd3, 1'b1, 2'd1);
    pulse_int();
    finish(3, 1, "R6 single acquisition block burst");

    // no further strobe: cycle-steal stalls between units
    launch(32'h40, 32'h90, 2, 2'd0, 1'b0, 2'd1);
    pulse_int();
    repeat (10) @(negedge clk);
    chk(m_op == 2 && !bus_req && busy && !done, "R5 waits for next request", m_op, 2);
    pulse_int();
    finish(2, 2, "R5 acquisition per unit");

    // external level released mid-burst
    launch(32'h300, 32'h700, 5, 2'd1, 1'b1, 2'd0);
    ext_req_n = 1'b0;
    while (!(mem_wr && mem_addr == 32'h702)) @(negedge clk);
    ext_req_n = 1'b1;
    @(negedge clk);
    chk(!bus_req && busy, "R7 bus released after level drop", {bus_req, busy}, 2'b01);
    repeat (6) @(negedge clk);
    chk(!bus_req && busy && !done && m_op == 4, "R7 holds off while level high", m_op, 4);
    ext_req_n = 1'b0;
    finish(5, 2, "R7 re-acquire after level returns");

    // burst requested with serial source: falls back
    launch(32'h500, 32'h600, 3, 2'd2, 1'b1, 2'd2);
    while (busy) pulse_int();
    finish(3, 3, "R8 fallback to cycle-steal");

    // random mix
    for (int it = 0; it < 14; it++) begin
      int n;
      logic [1:0] u, rs;
      bit bst;
      n = 1 + $urandom % 6;
      u = 2'($urandom);
      rs = 2'($urandom);
      bst = 1'($urandom);
      launch($urandom, $urandom, n, u, bst, rs);
      if (rs == 2'd0) ext_req_n = 1'b0;
      else while (busy) pulse_int();
      finish(n, (bst && !rs[1]) ? 1 : n, "R5 R6 R8 acquisitions");
    end

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired (R1..R10 incomplete) actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule